// File: doc/BRIEF.md
# Cache Test Access Controller

This block is the test-register front end of a small two-way set-associative cache model that keeps code and data in separate arrays. Each array has 128 sets and two ways per set. A line holds eight 32-bit words and carries a valid bit and a dirty bit. Software never addresses the cache directly. Instead it writes a packed 64-bit control word on a strobe. The low two bits of that word pick one of four operations: a plain control update, a test write of one word, a test read of one word, or a line flush.

A test write stores the word presented on the test data input into the addressed slot and marks the line valid. A test read returns the addressed word, together with that line's valid and dirty state, on a readback port that carries a valid flag. A flush invalidates one line. For a data line with write-back mode selected, the flush first sends all eight words of a dirty line out through a valid/ready port, and the block stays busy until the last word has been accepted. The last accepted control word can be read back at any time, with its reserved bits forced to zero.

Top module: `cache_test_ctrl`

## Requirements
- R1: After reset the control readback is zero, the readback, busy and writeback-valid flags are low, and every line in both arrays reads back as invalid and clean.
- R2: Operation code 2'b00 (bits 1:0) stores the control word for readback and leaves every array word, valid bit and dirty bit unchanged.
- R3: The control word fields are laid out as follows: bits 11:5 give the set, bit 12 the way, bits 4:2 the 32-bit word within the line, and bit 13 the array (1 = data, 0 = code). Every distinct combination of these fields addresses separate storage.
- R4: A test write (op 2'b01) stores test_data_i and sets the line's valid bit. It sets the dirty bit only when it targets the data array and bit 14 (write-back mode) is 1. A code line never becomes dirty.
- R5: A test read (op 2'b10) presents the addressed word, the line's valid bit and its dirty bit on the cycle after the strobe and raises rdata_valid_o. That flag stays high until the next accepted control write that is not a test read.
- R6: Bits 63:20 and 18:15 of ctrl_o always read as zero. Setting those bits in a control write has no effect on the operation performed.
- R7: A flush (op 2'b11) with bit 13 = 0 invalidates the addressed code line. It starts no writeback and leaves the data line at the same set and way untouched.
- R8: A flush with bit 13 = 1 and bit 14 = 0 invalidates and cleans the addressed data line at once, without any writeback, even when the line is dirty.
- R9: A flush with bits 13 and 14 both set on a valid dirty data line raises busy_o on the next cycle. It then offers words 0 to 7 of the line in ascending order on wb_valid_o/wb_ready_i, and holds each word stable while wb_ready_i is low. Busy drops and the line becomes invalid on the cycle after word 7 is accepted.
- R10: The same flush on a clean or invalid data line invalidates it at once and never raises busy_o or wb_valid_o.
- R11: A control write that arrives while busy_o is high is ignored. It changes neither ctrl_o nor any array state.
- R12: A data-array test write with bit 14 = 0 never sets the dirty bit and leaves an existing dirty bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_word_i | input | 64 | Packed control word |
| test_data_i | input | 32 | Data source for test writes |
| ctrl_o | output | 64 | Last accepted control word, reserved bits zeroed |
| rdata_o | output | 32 | Word returned by the last test read |
| rdata_valid_o | output | 1 | Readback holds a test read result |
| line_valid_o | output | 1 | Valid bit of the line read |
| line_dirty_o | output | 1 | Dirty bit of the line read |
| busy_o | output | 1 | Writeback in progress |
| wb_valid_o | output | 1 | Writeback word offered |
| wb_ready_i | input | 1 | Writeback word accepted |
| wb_set_o | output | 7 | Set of the line being written back |
| wb_way_o | output | 1 | Way of the line being written back |
| wb_word_o | output | 3 | Word index of the current writeback beat |
| wb_data_o | output | 32 | Writeback word |

## Verification
The same set, way and word index is written in the code array, in the data array and in both ways, each with a different value. Reading each one back separates the array-select, way and set fields from one another. Flushes are issued across the code/data bit and the write-back bit, and against dirty, clean and invalid lines. Comparing the resulting valid and dirty bits, and whether a writeback appears at all, tells the three flush actions apart. During a writeback the ready input is held low for one beat and a control write is injected, which shows both the beat holding stable and control writes being dropped while busy.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int CTRL_W = 64;
  localparam int SET_W  = 7;
  localparam int WAY_W  = 1;
  localparam int WORD_W = 3;
  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 1 << WAY_W;
  localparam int WORDS  = 1 << WORD_W;
  localparam logic [CTRL_W-1:0] KEEP_MASK = 64'h0000_0000_0008_7FFF;

  typedef enum logic [1:0] {
    OP_NORM  = 2'b00,
    OP_TWR   = 2'b01,
    OP_TRD   = 2'b10,
    OP_FLUSH = 2'b11
  } op_e;

  typedef struct packed {
    logic              wbm;
    logic              dsel;
    logic [WAY_W-1:0]  way;
    logic [SET_W-1:0]  set;
    logic [WORD_W-1:0] word;
    op_e               op;
  } cmd_t;
endpackage

// File: rtl/ctp_decode.sv
module ctp_decode
  import ctp_pkg::*;
(
  input  logic [CTRL_W-1:0] word_i,
  output cmd_t              cmd_o,
  output logic [CTRL_W-1:0] clean_o
);
  assign clean_o    = word_i & KEEP_MASK;
  assign cmd_o.op   = op_e'(word_i[1:0]);
  assign cmd_o.word = word_i[4:2];
  assign cmd_o.set  = word_i[11:5];
  assign cmd_o.way  = word_i[12];
  assign cmd_o.dsel = word_i[13];
  assign cmd_o.wbm  = word_i[14];
endmodule

// File: rtl/ctp_array.sv
module ctp_array #(
  parameter int SET_W  = 7,
  parameter int WAY_W  = 1,
  parameter int WORD_W = 3,
  parameter int DW     = 32,
  localparam int LINE_W = SET_W + WAY_W,
  localparam int LINES  = 1 << LINE_W,
  localparam int ENTRIES = 1 << (LINE_W + WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              mark_dirty_i,
  input  logic              inv_en_i,
  input  logic [SET_W-1:0]  inv_set_i,
  input  logic [WAY_W-1:0]  inv_way_i,
  input  logic [SET_W-1:0]  rd_set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_dirty_o
);
  logic [DW-1:0]    mem_q [ENTRIES];
  logic [LINES-1:0] valid_q, dirty_q;
  logic [LINE_W-1:0] wl, il, rl;

  assign wl = {wr_set_i, wr_way_i};
  assign il = {inv_set_i, inv_way_i};
  assign rl = {rd_set_i, rd_way_i};

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wl, wr_word_i}] <= wr_data_i;
  end

  // write and invalidate are never requested in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (wr_en_i) begin
        valid_q[wl] <= 1'b1;
        if (mark_dirty_i) dirty_q[wl] <= 1'b1;
      end
      if (inv_en_i) begin
        valid_q[il] <= 1'b0;
        dirty_q[il] <= 1'b0;
      end
    end
  end

  assign rd_data_o  = mem_q[{rl, rd_word_i}];
  assign rd_valid_o = valid_q[rl];
  assign rd_dirty_o = dirty_q[rl];
endmodule

// File: rtl/ctp_wb_seq.sv
module ctp_wb_seq #(
  parameter int SET_W  = 7,
  parameter int WAY_W  = 1,
  parameter int WORD_W = 3,
  localparam logic [WORD_W-1:0] LAST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  way_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic [SET_W-1:0]  set_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  logic              busy_q;
  logic [WORD_W-1:0] cnt_q;
  logic [SET_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      set_q  <= '0;
      way_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      set_q  <= set_i;
      way_q  <= way_i;
    end else if (busy_q && ready_i) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign set_o  = set_q;
  assign way_o  = way_q;
  assign word_o = cnt_q;
  assign done_o = busy_q && ready_i && (cnt_q == LAST);
endmodule

// File: rtl/cache_test_ctrl.sv
module cache_test_ctrl
  import ctp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic [DW-1:0]     test_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rdata_valid_o,
  output logic              line_valid_o,
  output logic              line_dirty_o,
  output logic              busy_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [SET_W-1:0]  wb_set_o,
  output logic [WAY_W-1:0]  wb_way_o,
  output logic [WORD_W-1:0] wb_word_o,
  output logic [DW-1:0]     wb_data_o
);
  localparam int NARR = 2;  // index 0 code, 1 data

  cmd_t              cmd;
  logic [CTRL_W-1:0] clean;
  logic              accept, flush, need_wb, wb_done;

  logic [DW-1:0]     a_rdata [NARR];
  logic              a_valid [NARR];
  logic              a_dirty [NARR];
  logic              a_inv   [NARR];
  logic [SET_W-1:0]  a_iset  [NARR];
  logic [WAY_W-1:0]  a_iway  [NARR];
  logic [SET_W-1:0]  a_rset  [NARR];
  logic [WAY_W-1:0]  a_rway  [NARR];
  logic [WORD_W-1:0] a_rword [NARR];

  ctp_decode u_dec (.word_i(ctrl_word_i), .cmd_o(cmd), .clean_o(clean));

  assign accept  = ctrl_we_i && !busy_o;
  assign flush   = accept && (cmd.op == OP_FLUSH);
  assign need_wb = flush && cmd.dsel && cmd.wbm && a_valid[1] && a_dirty[1];

  ctp_wb_seq #(.SET_W(SET_W), .WAY_W(WAY_W), .WORD_W(WORD_W)) u_wb (
    .clk_i, .rst_ni,
    .start_i (need_wb),
    .set_i   (cmd.set),
    .way_i   (cmd.way),
    .ready_i (wb_ready_i),
    .busy_o  (busy_o),
    .set_o   (wb_set_o),
    .way_o   (wb_way_o),
    .word_o  (wb_word_o),
    .done_o  (wb_done)
  );

  always_comb begin
    a_inv[0]   = flush && !cmd.dsel;
    a_iset[0]  = cmd.set;
    a_iway[0]  = cmd.way;
    a_rset[0]  = cmd.set;
    a_rway[0]  = cmd.way;
    a_rword[0] = cmd.word;
    a_inv[1]   = (flush && cmd.dsel && !need_wb) || wb_done;
    a_iset[1]  = busy_o ? wb_set_o : cmd.set;
    a_iway[1]  = busy_o ? wb_way_o : cmd.way;
    a_rset[1]  = busy_o ? wb_set_o  : cmd.set;
    a_rway[1]  = busy_o ? wb_way_o  : cmd.way;
    a_rword[1] = busy_o ? wb_word_o : cmd.word;
  end

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    localparam logic IS_DATA = (a == 1);
    ctp_array #(.SET_W(SET_W), .WAY_W(WAY_W), .WORD_W(WORD_W), .DW(DW)) u_arr (
      .clk_i, .rst_ni,
      .wr_en_i      (accept && (cmd.op == OP_TWR) && (cmd.dsel == IS_DATA)),
      .wr_set_i     (cmd.set),
      .wr_way_i     (cmd.way),
      .wr_word_i    (cmd.word),
      .wr_data_i    (test_data_i),
      .mark_dirty_i (IS_DATA && cmd.wbm),
      .inv_en_i     (a_inv[a]),
      .inv_set_i    (a_iset[a]),
      .inv_way_i    (a_iway[a]),
      .rd_set_i     (a_rset[a]),
      .rd_way_i     (a_rway[a]),
      .rd_word_i    (a_rword[a]),
      .rd_data_o    (a_rdata[a]),
      .rd_valid_o   (a_valid[a]),
      .rd_dirty_o   (a_dirty[a])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o        <= '0;
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
      line_valid_o  <= 1'b0;
      line_dirty_o  <= 1'b0;
    end else if (accept) begin
      ctrl_o        <= clean;
      rdata_valid_o <= (cmd.op == OP_TRD);
      if (cmd.op == OP_TRD) begin
        rdata_o      <= a_rdata[cmd.dsel];
        line_valid_o <= a_valid[cmd.dsel];
        line_dirty_o <= a_dirty[cmd.dsel];
      end
    end
  end

  assign wb_valid_o = busy_o;
  assign wb_data_o  = a_rdata[1];
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [63:0] ctrl_word_i,
  input logic [63:0] ctrl_o,
  input logic        rdata_valid_o,
  input logic        line_dirty_o,
  input logic        busy_o,
  input logic        wb_valid_o,
  input logic        wb_ready_i,
  input logic [2:0]  wb_word_o,
  input logic [31:0] wb_data_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[63:20] == 44'd0) && (ctrl_o[18:15] == 4'd0)); // R6
  AST_BUSY_DROPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ctrl_o)); // R11
  AST_CODE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_valid_o && !ctrl_o[13]) |-> !line_dirty_o); // R4
  AST_RD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_valid_o) |-> $past(ctrl_we_i && !busy_o && ctrl_word_i[1:0] == 2'b10)); // R5
  AST_BUSY_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ctrl_we_i && ctrl_word_i[1:0] == 2'b11 && ctrl_word_i[14:13] == 2'b11)); // R9
  AST_WB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_valid_o) |-> (wb_word_o == 3'd0)); // R9
  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_word_o) && $stable(wb_data_o))); // R9
  AST_WB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ready_i && wb_word_o != 3'd7) |=> (wb_valid_o && wb_word_o == $past(wb_word_o) + 3'd1)); // R9
  AST_WB_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ready_i && wb_word_o == 3'd7) |=> !busy_o); // R9
endmodule

bind cache_test_ctrl ctp_checker i_chk (
  .clk_i, .rst_ni, .ctrl_we_i, .ctrl_word_i, .ctrl_o, .rdata_valid_o,
  .line_dirty_o, .busy_o, .wb_valid_o, .wb_ready_i, .wb_word_o, .wb_data_o
);

// File: tb/test_cache_test_ctrl.sv
module test_cache_test_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [63:0] ctrl_word = '0;
  logic [31:0] tdata = '0;
  logic [63:0] ctrl_q;
  logic [31:0] rdata, wb_data;
  logic        rvalid, lvalid, ldirty, busy, wb_valid;
  logic        wb_ready = 1'b0;
  logic [6:0]  wb_set;
  logic        wb_way;
  logic [2:0]  wb_word;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cache_test_ctrl i_cache_test_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_word_i(ctrl_word),
    .test_data_i(tdata), .ctrl_o(ctrl_q), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .line_valid_o(lvalid), .line_dirty_o(ldirty), .busy_o(busy), .wb_valid_o(wb_valid),
    .wb_ready_i(wb_ready), .wb_set_o(wb_set), .wb_way_o(wb_way), .wb_word_o(wb_word),
    .wb_data_o(wb_data)
  );

  function automatic logic [63:0] mk(input logic [1:0] op, input int set, input bit way,
                                     input int word, input bit dsel, input bit wbm);
    logic [63:0] w = '0;
    w[1:0] = op; w[4:2] = word[2:0]; w[11:5] = set[6:0];
    w[12] = way; w[13] = dsel; w[14] = wbm;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctrl(input logic [63:0] w, input logic [31:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_word = w; tdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic rd(input int set, input bit way, input int word, input bit dsel);
    ctrl(mk(2'b10, set, way, word, dsel, 1'b0), 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 ctrl_o", ctrl_q, 64'h0);
    chk("R1 rdata_valid", rvalid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wb_valid", wb_valid, 0);
    rd(0, 0, 0, 1);
    chk("R1 data line invalid", lvalid, 0);
    rd(127, 1, 7, 0);
    chk("R1 code line invalid", lvalid, 0);
    chk("R1 code line clean", ldirty, 0);
  endtask

  task automatic t_rw_fields;
    ctrl(mk(2'b01, 3, 0, 2, 1, 0), 32'h1111);
    ctrl(mk(2'b01, 3, 1, 2, 1, 0), 32'h2222);
    ctrl(mk(2'b01, 3, 0, 2, 0, 0), 32'h3333);
    ctrl(mk(2'b01, 100, 0, 7, 1, 0), 32'h4444);
    ctrl(mk(2'b01, 3, 0, 3, 1, 0), 32'h5555);
    rd(3, 0, 2, 1);
    chk("R3 data way0", rdata, 32'h1111);
    chk("R5 rdata_valid", rvalid, 1);
    chk("R5 line valid", lvalid, 1);
    rd(3, 1, 2, 1);
    chk("R3 data way1", rdata, 32'h2222);
    rd(3, 0, 2, 0);
    chk("R3 code array", rdata, 32'h3333);
    rd(100, 0, 7, 1);
    chk("R3 set 100 word 7", rdata, 32'h4444);
    rd(3, 0, 3, 1);
    chk("R3 word 3", rdata, 32'h5555);
    ctrl(mk(2'b00, 0, 0, 0, 0, 0), 32'h0);
    chk("R5 valid clears on other op", rvalid, 0);
  endtask

  task automatic t_normal;
    logic [63:0] w = mk(2'b00, 3, 0, 2, 1, 1);
    ctrl(w, 32'hDEAD);
    chk("R2 ctrl readback", ctrl_q, w);
    rd(3, 0, 2, 1);
    chk("R2 word unchanged", rdata, 32'h1111);
    chk("R2 dirty unchanged", ldirty, 0);
  endtask

  task automatic t_dirty;
    ctrl(mk(2'b01, 10, 0, 0, 1, 0), 32'hA);
    rd(10, 0, 0, 1);
    chk("R12 write-through clean", ldirty, 0);
    ctrl(mk(2'b01, 11, 0, 0, 1, 1), 32'hB);
    rd(11, 0, 0, 1);
    chk("R4 write-back dirty", ldirty, 1);
    ctrl(mk(2'b01, 12, 0, 0, 0, 1), 32'hC);
    rd(12, 0, 0, 0);
    chk("R4 code stays clean", ldirty, 0);
    chk("R4 code valid", lvalid, 1);
    ctrl(mk(2'b01, 11, 0, 1, 1, 0), 32'hD);
    rd(11, 0, 1, 1);
    chk("R12 dirty kept", ldirty, 1);
    chk("R12 data stored", rdata, 32'hD);
  endtask

  task automatic t_reserved;
    logic [63:0] junk = 64'hFFFF_FFFF_FFF0_0000 | 64'h0007_8000;
    logic [63:0] w = mk(2'b00, 5, 1, 4, 0, 1);
    ctrl(w | junk, 32'h0);
    chk("R6 reserved read zero", ctrl_q, w);
    ctrl(mk(2'b01, 20, 0, 1, 1, 0) | junk, 32'h55);
    rd(20, 0, 1, 1);
    chk("R6 write unaffected", rdata, 32'h55);
    chk("R6 no dirty from reserved", ldirty, 0);
  endtask

  task automatic t_flush_code;
    ctrl(mk(2'b11, 3, 0, 0, 0, 1), 32'h0);
    chk("R7 no busy", busy, 0);
    rd(3, 0, 2, 0);
    chk("R7 code invalid", lvalid, 0);
    rd(3, 0, 2, 1);
    chk("R7 data untouched valid", lvalid, 1);
    chk("R7 data untouched word", rdata, 32'h1111);
  endtask

  task automatic t_flush_nowb;
    ctrl(mk(2'b11, 11, 0, 0, 1, 0), 32'h0);
    chk("R8 no busy", busy, 0);
    chk("R8 no wb", wb_valid, 0);
    rd(11, 0, 0, 1);
    chk("R8 invalid", lvalid, 0);
    chk("R8 clean", ldirty, 0);
  endtask

  task automatic t_flush_wb;
    logic [63:0] fw = mk(2'b11, 5, 1, 0, 1, 1);
    for (int i = 0; i < 8; i++) ctrl(mk(2'b01, 5, 1, i, 1, 1), 32'hA000_0000 + i * 3);
    ctrl(fw, 32'h0);
    chk("R9 busy", busy, 1);
    chk("R9 set", wb_set, 5);
    chk("R9 way", wb_way, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R9 wb valid", wb_valid, 1);
      chk("R9 word order", wb_word, i);
      chk("R9 word data", wb_data, 32'hA000_0000 + i * 3);
      if (i == 2) begin
        ctrl_we = 1'b1; ctrl_word = mk(2'b01, 9, 0, 0, 0, 0); tdata = 32'h99;
        @(negedge clk);
        ctrl_we = 1'b0;
        chk("R11 ctrl_o unchanged", ctrl_q, fw);
        chk("R9 stall holds word", wb_word, 2);
        chk("R9 stall holds data", wb_data, 32'hA000_0006);
      end
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
    end
    chk("R9 busy done", busy, 0);
    chk("R9 wb valid done", wb_valid, 0);
    rd(5, 1, 0, 1);
    chk("R9 line invalid", lvalid, 0);
    rd(9, 0, 0, 0);
    chk("R11 dropped write", lvalid, 0);
  endtask

  task automatic t_flush_clean;
    ctrl(mk(2'b01, 40, 0, 0, 1, 0), 32'h40);
    ctrl(mk(2'b11, 40, 0, 0, 1, 1), 32'h0);
    chk("R10 no busy", busy, 0);
    chk("R10 no wb", wb_valid, 0);
    rd(40, 0, 0, 1);
    chk("R10 invalid", lvalid, 0);
    ctrl(mk(2'b11, 41, 1, 0, 1, 1), 32'h0);
    chk("R10 invalid line no busy", busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw_fields;
    t_normal;
    t_dirty;
    t_reserved;
    t_flush_code;
    t_flush_nowb;
    t_flush_wb;
    t_flush_clean;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule